// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block gathers every reason the chip might need to be held in reset into one active-low system reset. It also raises a ready flag once the system may run. Four causes are filtered in the clock domain: an active-low reset pin and three rail undervoltage flags (0.9 V, 1.2 V and 1.5 V). A power-good input acts as the fifth cause. While it is low, every register in the block is held asynchronously, so the system reset is low at once. Each filtered cause must stay in its new state for its own number of clock cycles before it counts. Brief glitches therefore never reach the system.

Once no cause is active, the block holds reset for a configurable wait. This gives mode pins and slow internal supplies time to settle before release. A cause that comes back during the wait sends the block back to holding, and the full wait starts over. A small status register records which causes brought the running system into reset. Software reads it after release and clears it bit by bit with a write-one-to-clear pulse vector.

All durations are parameters counted in clock cycles. Each of the four filtered inputs first passes through a two-stage synchronizer.

Top module: `rst_sequencer`

## Requirements
- R1: With the block running, a low level on `extRstN` drives `sysRstN` low on exactly the (EXT_SET_CYC+2)-th rising edge after the pin falls. The count is two synchronizer stages plus EXT_SET_CYC filter samples.
- R2: A low pulse on `extRstN` lasting fewer than EXT_SET_CYC cycles has no effect on `sysRstN`, `sysReady` or `causeStatus`.
- R3: After `extRstN` returns high, the pin cause clears on the (EXT_CLR_CYC+2)-th edge. `sysRstN` then rises CFG_WAIT+1 edges later.
- R4: A high level on `lvd09` held for LVD09_CYC cycles forces reset on edge LVD09_CYC+2. A shorter pulse is ignored.
- R5: The same holds for `lvd12` with LVD12_CYC.
- R6: The same holds for `lvd15` with LVD15_CYC, a longer window than the other two rails. Each rail clears one sample after its flag drops.
- R7: While `pwrGood` is low, `sysRstN` and `sysReady` are 0 and `causeStatus` is 5'b00001, with no clock edge needed.
- R8: The block leaves hold on the first edge with no active cause. It releases `sysRstN` and raises `sysReady` exactly CFG_WAIT edges later. After `pwrGood` rises, this means release on edge CFG_WAIT+1.
- R9: If any cause becomes active during the wait, the block returns to hold. The wait then restarts from zero after the cause clears.
- R10: When a cause hits a running system, `causeStatus` is replaced on the next edge. The new value is bit1 = pin, bit2 = 0.9 V, bit3 = 1.2 V, bit4 = 1.5 V, bit0 = 0, with every cause active in that cycle recorded.
- R11: Each 1 in `clrCause` clears the matching `causeStatus` bit on the next edge. A capture on that same edge takes priority over the clear.
- R12: A cause hitting a running system drops `sysRstN` in the same cycle its filter fires. `sysReady` falls one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwrGood | input | 1 | Power ready; low asynchronously resets the block |
| extRstN | input | 1 | External reset pin, active low |
| lvd09 | input | 1 | 0.9 V rail undervoltage flag, active high |
| lvd12 | input | 1 | 1.2 V rail undervoltage flag, active high |
| lvd15 | input | 1 | 1.5 V rail undervoltage flag, active high |
| clrCause | input | 5 | Write-one-to-clear pulses for the status bits |
| sysRstN | output | 1 | System reset, active low |
| sysReady | output | 1 | High while the system runs |
| causeStatus | output | 5 | Sticky record of the causes of the latest reset |

## Verification
Two events can land on the same clock edge: a new capture of reset causes, and a software clear of the status bits. The bench raises the 0.9 V and 1.2 V flags together, so both filters fire in one cycle. It holds every `clrCause` bit high through the capture edge. The status must then show exactly those two rail bits, which proves that capture wins over clear and that simultaneous causes are both recorded. A later single-bit clear must remove only its own bit.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
  localparam int unsigned NUM_FILT = 4;   // pin, 0.9 V, 1.2 V, 1.5 V
  localparam int unsigned STAT_W   = NUM_FILT + 1;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic capture;
  } seqStrobe_t;
endpackage

// File: rtl/rstseq_filter.sv
`timescale 1ns/1ps
module rstseq_filter #(
  parameter int unsigned SET_CYC = 4,
  parameter int unsigned CLR_CYC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic q
);
  localparam int unsigned MAXC = (SET_CYC > CLR_CYC) ? SET_CYC : CLR_CYC;
  localparam int unsigned W    = $clog2(MAXC + 1);

  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  assign lim = q ? W'(CLR_CYC - 1) : W'(SET_CYC - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (din != q) begin
      if (cnt == lim) begin
        q   <= din;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // R2: a cause only turns on after a full run of active samples
  p_min_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(q) |-> ($past(din) && $past(cnt) == W'(SET_CYC - 1)));
endmodule

// File: rtl/rstseq_datapath.sv
`timescale 1ns/1ps
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int unsigned EXT_SET_CYC = 50,
  parameter int unsigned EXT_CLR_CYC = 50,
  parameter int unsigned LVD09_CYC   = 400,
  parameter int unsigned LVD12_CYC   = 400,
  parameter int unsigned LVD15_CYC   = 800,
  parameter int unsigned CFG_WAIT    = 750000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_FILT-1:0]   rawCause,
  input  logic [STAT_W-1:0]     clrCause,
  input  seqStrobe_t            strobe,
  output logic                  anyCause,
  output logic                  waitDone,
  output logic [STAT_W-1:0]     causeStatus
);
  localparam int unsigned WW = $clog2(CFG_WAIT + 1);

  logic [NUM_FILT-1:0] syncA, syncB, filt;
  logic [WW-1:0]       waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= rawCause;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
    localparam int unsigned SETC = (i == 0) ? EXT_SET_CYC :
                                   (i == 1) ? LVD09_CYC :
                                   (i == 2) ? LVD12_CYC : LVD15_CYC;
    localparam int unsigned CLRC = (i == 0) ? EXT_CLR_CYC : 1;
    rstseq_filter #(.SET_CYC(SETC), .CLR_CYC(CLRC)) u_filt (
      .clk (clk),
      .rstN(rstN),
      .din (syncB[i]),
      .q   (filt[i])
    );
  end

  assign anyCause = |filt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              waitCnt <= '0;
    else if (strobe.cntClr) waitCnt <= '0;
    else if (strobe.cntEn)  waitCnt <= waitCnt + 1'b1;
  end

  assign waitDone = (waitCnt == WW'(CFG_WAIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               causeStatus <= STAT_W'(1);
    else if (strobe.capture) causeStatus <= {filt, 1'b0};
    else                     causeStatus <= causeStatus & ~clrCause;
  end

  // R8: the wait counter never runs past its terminal value
  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WW'(CFG_WAIT - 1));

  // R10: a capture records exactly the causes active in that cycle
  p_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capture) |-> (causeStatus == {$past(filt), 1'b0}));
endmodule

// File: rtl/rstseq_ctrl.sv
`timescale 1ns/1ps
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyCause,
  input  logic       waitDone,
  output seqStrobe_t strobe,
  output logic       sysRstN,
  output logic       sysReady
);
  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_HOLD: if (!anyCause) begin
        stateNxt      = ST_WAIT;
        strobe.cntClr = 1'b1;
      end
      ST_WAIT: begin
        if (anyCause)      stateNxt = ST_HOLD;
        else if (waitDone) stateNxt = ST_RUN;
        else               strobe.cntEn = 1'b1;
      end
      ST_RUN: if (anyCause) begin
        stateNxt       = ST_HOLD;
        strobe.capture = 1'b1;
      end
      default: stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNxt;
  end

  assign sysReady = (state == ST_RUN);
  assign sysRstN  = (state == ST_RUN) && !anyCause;

  // R8: release only from the wait after its count completed cleanly
  p_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) != ST_RUN) |->
      ($past(state) == ST_WAIT && $past(waitDone) && !$past(anyCause)));

  // R12: a cause seen while running leaves the run state on the next edge
  p_drop_ready_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && anyCause) |=> (state == ST_HOLD && !sysReady));

  // R9: the wait never proceeds to run while a cause is present
  p_wait_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && anyCause) |=> (state == ST_HOLD));
endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/1ps
module rst_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned EXT_SET_CYC = 50,
  parameter int unsigned EXT_CLR_CYC = 50,
  parameter int unsigned LVD09_CYC   = 400,
  parameter int unsigned LVD12_CYC   = 400,
  parameter int unsigned LVD15_CYC   = 800,
  parameter int unsigned CFG_WAIT    = 750000
) (
  input  logic       clk,
  input  logic       pwrGood,
  input  logic       extRstN,
  input  logic       lvd09,
  input  logic       lvd12,
  input  logic       lvd15,
  input  logic [4:0] clrCause,
  output logic       sysRstN,
  output logic       sysReady,
  output logic [4:0] causeStatus
);
  seqStrobe_t strobe;
  logic       anyCause;
  logic       waitDone;

  rstseq_datapath #(
    .EXT_SET_CYC(EXT_SET_CYC), .EXT_CLR_CYC(EXT_CLR_CYC),
    .LVD09_CYC(LVD09_CYC), .LVD12_CYC(LVD12_CYC),
    .LVD15_CYC(LVD15_CYC), .CFG_WAIT(CFG_WAIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (pwrGood),
    .rawCause   ({lvd15, lvd12, lvd09, ~extRstN}),
    .clrCause   (clrCause),
    .strobe     (strobe),
    .anyCause   (anyCause),
    .waitDone   (waitDone),
    .causeStatus(causeStatus)
  );

  rstseq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (pwrGood),
    .anyCause(anyCause),
    .waitDone(waitDone),
    .strobe  (strobe),
    .sysRstN (sysRstN),
    .sysReady(sysReady)
  );
endmodule

// File: tb/tb_rst_sequencer.sv
`timescale 1ns/1ps
module tb_rst_sequencer;
  localparam int EA  = 5;
  localparam int ER  = 6;
  localparam int L09 = 8;
  localparam int L12 = 8;
  localparam int L15 = 16;
  localparam int CFG = 40;

  logic       clk = 1'b0;
  logic       pwrGood = 1'b0;
  logic       extRstN = 1'b1;
  logic [2:0] lvdVec = 3'b000;
  logic [4:0] clrCause = 5'b0;
  logic       sysRstN, sysReady;
  logic [4:0] causeStatus;
  int         nChecks = 0;
  int         nFails = 0;

  always #10 clk = ~clk;   // 50 MHz

  rst_sequencer #(
    .EXT_SET_CYC(EA), .EXT_CLR_CYC(ER), .LVD09_CYC(L09),
    .LVD12_CYC(L12), .LVD15_CYC(L15), .CFG_WAIT(CFG)
  ) dut (
    .clk(clk), .pwrGood(pwrGood), .extRstN(extRstN),
    .lvd09(lvdVec[0]), .lvd12(lvdVec[1]), .lvd15(lvdVec[2]),
    .clrCause(clrCause), .sysRstN(sysRstN), .sysReady(sysReady),
    .causeStatus(causeStatus)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    clrCause = 5'h1F;
    tick(1);
    clrCause = 5'h00;
    check("R11 clear all", causeStatus, 0);
  endtask

  task automatic testResetState();
    tick(3);
    check("R7 rst low", sysRstN, 0);
    check("R7 ready low", sysReady, 0);
    check("R7 status", causeStatus, 5'b00001);
  endtask

  task automatic testPowerUp();
    pwrGood = 1'b1;
    tick(CFG);
    check("R8 held during wait", sysRstN, 0);
    tick(1);
    check("R8 released", sysRstN, 1);
    check("R12 ready with release", sysReady, 1);
  endtask

  task automatic testExtShort();
    extRstN = 1'b0;
    tick(EA - 1);
    extRstN = 1'b1;
    tick(EA + 4);
    check("R2 short pulse rst", sysRstN, 1);
    check("R2 short pulse ready", sysReady, 1);
    check("R2 short pulse status", causeStatus, 0);
  endtask

  task automatic testExtAssertRelease();
    extRstN = 1'b0;
    tick(EA + 1);
    check("R1 not yet", sysRstN, 1);
    tick(1);
    check("R1 asserted", sysRstN, 0);
    check("R12 ready lags", sysReady, 1);
    tick(1);
    check("R12 ready drops", sysReady, 0);
    check("R10 pin bit", causeStatus, 5'b00010);
    extRstN = 1'b1;
    tick(ER + 2 + CFG);
    check("R3 still held", sysRstN, 0);
    tick(1);
    check("R3 released", sysRstN, 1);
  endtask

  task automatic testRestart();
    extRstN = 1'b0;
    tick(EA + 3);
    extRstN = 1'b1;
    tick(ER + 3 + CFG / 2);
    check("R9 mid wait", sysRstN, 0);
    extRstN = 1'b0;
    tick(EA);
    extRstN = 1'b1;
    tick(ER + 2 + CFG);
    check("R9 wait restarted", sysRstN, 0);
    tick(1);
    check("R9 release after full wait", sysRstN, 1);
  endtask

  task automatic testRail(input int idx, input int lim, input string req);
    lvdVec[idx] = 1'b1;
    tick(lim - 1);
    lvdVec[idx] = 1'b0;
    tick(lim + 4);
    check({req, " short ignored"}, sysRstN, 1);
    lvdVec[idx] = 1'b1;
    tick(lim + 1);
    check({req, " not yet"}, sysRstN, 1);
    tick(1);
    check({req, " asserted"}, sysRstN, 0);
    tick(1);
    check({req, " R10 status"}, causeStatus, 32'(1) << (idx + 2));
    lvdVec[idx] = 1'b0;
    tick(3 + CFG);
    check({req, " held"}, sysRstN, 0);
    tick(1);
    check({req, " released"}, sysRstN, 1);
  endtask

  task automatic testCaptureBeatsClear();
    lvdVec[1:0] = 2'b11;
    clrCause = 5'h1F;
    tick(L09 + 3);
    clrCause = 5'h00;
    check("R11 capture wins over clear", causeStatus, 5'b01100);
    check("R10 both rails", sysRstN, 0);
    lvdVec[1:0] = 2'b00;
    tick(3 + CFG + 1);
    check("R8 release after rails", sysRstN, 1);
    clrCause = 5'b00100;
    tick(1);
    clrCause = 5'b00000;
    check("R11 single bit clear", causeStatus, 5'b01000);
  endtask

  task automatic testPowerDrop();
    pwrGood = 1'b0;
    #1;
    check("R7 async rst", sysRstN, 0);
    check("R7 async ready", sysReady, 0);
    check("R7 async status", causeStatus, 5'b00001);
  endtask

  initial begin
    testResetState();
    testPowerUp();
    clearAll();
    testExtShort();
    testExtAssertRelease();
    clearAll();
    testRestart();
    testRail(0, L09, "R4");
    testRail(1, L12, "R5");
    testRail(2, L15, "R6");
    testCaptureBeatsClear();
    testPowerDrop();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule